// File: doc/BRIEF.md
# Bank State Tracker with Auto-Precharge

This block follows the row state of every bank in a multi-bank synchronous DRAM, as seen by the memory controller. It watches the stream of decoded commands and keeps, for each bank, whether a row is open, waiting for an automatic precharge, or precharging. From that state it works out two things. It tells when an activate may go to each bank. It tells when the whole device is idle enough to accept an auto-refresh.

Each bank has its own down-counters. One counts the minimum row-active time from the activate. One counts the precharge time. One counts the delay before an automatic precharge. A read with auto-precharge closes its bank a fixed number of cycles after the command, and waits longer if the row-active minimum has not yet passed. A write with auto-precharge closes after write latency, burst and write recovery. Once started, either one cannot be interrupted. The block flags any command that breaks these rules and does not act on it. The controller uses the open-bank outputs to sort a power-down entry into the active class or the precharge class.

Top module: `bank_state_tracker`

## Requirements
- R1: Opcodes on `cmd_op` are 0 no-op, 1 activate, 2 precharge, 3 read, 4 write and 5 refresh. Codes 6 and 7 act as no-op. After reset every bank is closed and ready to activate, `pre_busy` is low and `violation` is low.
- R2: An activate sampled at a clock edge opens the addressed bank. From that edge, `bank_open` for that bank is high and `act_ready` for it is low.
- R3: An activate to a bank that is open, waiting for auto-precharge, or still inside its precharge time is ignored and raises `violation`.
- R4: A precharge with `cmd_flag` low closes only the bank on `cmd_bank`. A precharge with `cmd_flag` high closes every open bank. A precharge to a bank that is closed or already precharging has no effect and is legal.
- R5: A precharge that reaches an open bank fewer than TRAS edges after its activate leaves that bank open and raises `violation`.
- R6: A bank that starts precharging at edge p shows `pre_busy` until it is idle. It accepts an activate at edge p+TRP at the earliest. Its `act_ready` goes high after edge p+TRP-1.
- R7: A read with `cmd_flag` high starts the bank's precharge at edge AL+BL/2 after the command. If TRAS edges have not yet passed since the activate, the precharge starts at the first edge where they have.
- R8: A write with `cmd_flag` high starts the bank's precharge WL+BL/2+TWR edges after the command, with WL = AL+1. The next activate to that bank is accepted WL+BL/2+TWR+TRP edges after the command.
- R9: While a bank waits for its automatic precharge, any precharge, read, write or activate addressed to it is ignored and raises `violation`.
- R10: A read or write to a bank with no open row raises `violation`.
- R11: `ref_ok` is high only when every bank is closed and its precharge time has run out. A refresh sampled while `ref_ok` is low raises `violation`.
- R12: `pd_active` is high exactly when at least one bank has an open row, which makes a power-down entry the active kind. Low means the precharge kind.
- R13: `violation` is registered. It is high for one cycle after the edge that sampled each offending command, and low after a legal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Decoded command opcode (R1 encoding) |
| cmd_bank | input | BANK_W | Addressed bank |
| cmd_flag | input | 1 | All-bank select on precharge, auto-precharge on read or write |
| bank_open | output | NUM_BANKS | Row open in bank (including waiting for auto-precharge) |
| act_ready | output | NUM_BANKS | Bank may accept an activate at the next edge |
| pre_busy | output | 1 | At least one bank is precharging |
| ref_ok | output | 1 | All banks idle with precharge time elapsed |
| pd_active | output | 1 | At least one row open (active power-down class) |
| violation | output | 1 | Previous command broke a protocol rule |

## Verification
The bench targets the edge where each wait ends. It sends an activate in the last precharge cycle and expects it to be accepted. It sends another one cycle too early and expects it to be rejected. A counter that is off by one would either reject the first or open the bank on the second. It issues a read with auto-precharge soon after an activate, so the row-active minimum, not the burst delay, decides when the bank closes. A design that ignored this rule would close the bank two edges early. It sends precharges and reads to a bank that is waiting for auto-precharge, and a precharge-all while one bank is still too young. A design that let these through would close the wrong bank or shorten the write-recovery window.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_PRE = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4,
    OP_REF = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_APWAIT,
    BK_PRECH
  } bank_st_e;
endpackage

// File: rtl/bst_bank.sv
module bst_bank #(
  parameter int TRAS = 6,
  parameter int TRP  = 3,
  parameter int D_RD = 3,
  parameter int D_WR = 7,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  bst_pkg::op_e  op,
  input  logic          all_flag,
  output logic          row_open,
  output logic          precharging,
  output logic          act_ok,
  output logic          viol
);
  import bst_pkg::*;

  bank_st_e        st;
  logic [CW-1:0]   ras_cnt;
  logic [CW-1:0]   rp_cnt;
  logic [CW-1:0]   ap_cnt;

  logic act_hit, pre_hit, rd_hit, wr_hit, ras_done, rp_done;

  assign act_hit  = sel && (op == OP_ACT);
  assign pre_hit  = (op == OP_PRE) && (sel || all_flag);
  assign rd_hit   = sel && (op == OP_RD);
  assign wr_hit   = sel && (op == OP_WR);
  assign ras_done = (ras_cnt == '0);
  assign rp_done  = (rp_cnt == '0);

  assign row_open    = (st == BK_OPEN) || (st == BK_APWAIT);
  assign precharging = (st == BK_PRECH);
  assign act_ok      = (st == BK_IDLE) || ((st == BK_PRECH) && rp_done);

  always_comb begin
    viol = 1'b0;
    if (act_hit && !act_ok)                          viol = 1'b1;
    if (pre_hit && (st == BK_OPEN) && !ras_done)     viol = 1'b1;
    if (pre_hit && (st == BK_APWAIT))                viol = 1'b1;
    if ((rd_hit || wr_hit) && (st != BK_OPEN))       viol = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BK_IDLE;
      ras_cnt <= '0;
      rp_cnt  <= '0;
      ap_cnt  <= '0;
    end else begin
      if (!ras_done) ras_cnt <= ras_cnt - CW'(1);
      unique case (st)
        BK_IDLE: begin
          if (act_hit) begin
            st      <= BK_OPEN;
            ras_cnt <= CW'(TRAS - 1);
          end
        end
        BK_OPEN: begin
          if (pre_hit && ras_done) begin
            st     <= BK_PRECH;
            rp_cnt <= CW'(TRP - 1);
          end else if ((rd_hit || wr_hit) && all_flag) begin
            st     <= BK_APWAIT;
            ap_cnt <= rd_hit ? CW'(D_RD - 1) : CW'(D_WR - 1);
          end
        end
        BK_APWAIT: begin
          if (ap_cnt != '0) begin
            ap_cnt <= ap_cnt - CW'(1);
          end else if (ras_done) begin
            st     <= BK_PRECH;
            rp_cnt <= CW'(TRP - 1);
          end
        end
        BK_PRECH: begin
          if (act_hit && rp_done) begin
            st      <= BK_OPEN;
            ras_cnt <= CW'(TRAS - 1);
          end else if (rp_done) begin
            st <= BK_IDLE;
          end else begin
            rp_cnt <= rp_cnt - CW'(1);
          end
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  // R5
  ras_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN && ras_cnt != '0) |=> (st != BK_PRECH));

  // R6
  rp_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_PRECH && rp_cnt != '0) |=> (st == BK_PRECH));

  // R9
  ap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_APWAIT && ap_cnt != '0) |=> (st == BK_APWAIT));

  // R7
  ap_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_APWAIT && ras_cnt != '0) |=> (st == BK_APWAIT));
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int TRAS      = 6,
  parameter int TRP       = 3,
  parameter int TWR       = 3,
  parameter int BL        = 4,
  parameter int AL        = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_flag,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] act_ready,
  output logic                 pre_busy,
  output logic                 ref_ok,
  output logic                 pd_active,
  output logic                 violation
);
  import bst_pkg::*;

  localparam int WL    = AL + 1;
  localparam int D_RD  = AL + BL / 2;
  localparam int D_WR  = WL + BL / 2 + TWR;
  localparam int MAX1  = (TRAS > TRP) ? TRAS : TRP;
  localparam int MAXC  = (MAX1 > D_WR) ? MAX1 : D_WR;
  localparam int CW    = $clog2(MAXC + 1);

  op_e                  op;
  logic [NUM_BANKS-1:0] bank_prech;
  logic [NUM_BANKS-1:0] bank_viol;
  logic                 ref_bad;

  assign op = op_e'(cmd_op);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bst_bank #(
      .TRAS(TRAS), .TRP(TRP), .D_RD(D_RD), .D_WR(D_WR), .CW(CW)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .sel        (cmd_bank == BANK_W'(b)),
      .op         (op),
      .all_flag   (cmd_flag),
      .row_open   (bank_open[b]),
      .precharging(bank_prech[b]),
      .act_ok     (act_ready[b]),
      .viol       (bank_viol[b])
    );
  end

  assign pre_busy  = |bank_prech;
  assign ref_ok    = &act_ready;
  assign pd_active = |bank_open;
  assign ref_bad   = (op == OP_REF) && !ref_ok;

  always_ff @(posedge clk) begin
    if (rst) violation <= 1'b0;
    else     violation <= (|bank_viol) || ref_bad;
  end

  // R3
  act_open_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACT && bank_open[cmd_bank]) |=> violation);

  // R10
  rdwr_closed_chk: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_RD || op == OP_WR) && !bank_open[cmd_bank]) |=> violation);

  // R11
  ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> !pd_active);

  // R2
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACT && act_ready[cmd_bank]) |=> bank_open[$past(cmd_bank)]);
endmodule

// File: tb/bank_state_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_state_tracker_tb_top;
  localparam int NV = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_flag = 1'b0;
  logic [3:0] bank_open, act_ready;
  logic       pre_busy, ref_ok, pd_active, violation;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bank_state_tracker dut_i (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_flag(cmd_flag), .bank_open(bank_open), .act_ready(act_ready),
    .pre_busy(pre_busy), .ref_ok(ref_ok), .pd_active(pd_active),
    .violation(violation)
  );

  // Row: tag[19:16] op[15:13] bank[12:11] flag[10] open[9:6] ready[5:2] busy[1] viol[0]
  // Defaults: TRAS=6 TRP=3 TWR=3 BL=4 AL=1 -> read AP delay 3, write AP delay 7
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 3'd1,2'd0,1'b0, 4'b0001,4'b1110,1'b0,1'b0}, // 0  R2 open b0
    {4'd2, 3'd1,2'd1,1'b0, 4'b0011,4'b1100,1'b0,1'b0}, // 1  R2 open b1
    {4'd3, 3'd1,2'd0,1'b0, 4'b0011,4'b1100,1'b0,1'b1}, // 2  R3 act on open bank
    {4'd5, 3'd2,2'd0,1'b0, 4'b0011,4'b1100,1'b0,1'b1}, // 3  R5 precharge too early
    {4'd13,3'd0,2'd0,1'b0, 4'b0011,4'b1100,1'b0,1'b0}, // 4  R13 pulse drops
    {4'd5, 3'd0,2'd0,1'b0, 4'b0011,4'b1100,1'b0,1'b0}, // 5  R5
    {4'd4, 3'd2,2'd0,1'b0, 4'b0010,4'b1100,1'b1,1'b0}, // 6  R4 single close b0
    {4'd6, 3'd0,2'd0,1'b0, 4'b0010,4'b1100,1'b1,1'b0}, // 7  R6
    {4'd6, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b1,1'b0}, // 8  R6 ready one early
    {4'd6, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 9  R6
    {4'd7, 3'd3,2'd1,1'b1, 4'b0010,4'b1101,1'b0,1'b0}, // 10 R7 read AP b1
    {4'd7, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 11 R7
    {4'd7, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 12 R7
    {4'd7, 3'd0,2'd0,1'b0, 4'b0000,4'b1101,1'b1,1'b0}, // 13 R7 closes at +3
    {4'd6, 3'd0,2'd0,1'b0, 4'b0000,4'b1101,1'b1,1'b0}, // 14 R6
    {4'd6, 3'd0,2'd0,1'b0, 4'b0000,4'b1111,1'b1,1'b0}, // 15 R6
    {4'd6, 3'd1,2'd1,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 16 R6 act at p+TRP
    {4'd7, 3'd3,2'd1,1'b1, 4'b0010,4'b1101,1'b0,1'b0}, // 17 R7 read AP, young row
    {4'd9, 3'd2,2'd1,1'b0, 4'b0010,4'b1101,1'b0,1'b1}, // 18 R9 precharge during AP
    {4'd9, 3'd3,2'd1,1'b0, 4'b0010,4'b1101,1'b0,1'b1}, // 19 R9 read during AP
    {4'd7, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 20 R7 held by TRAS
    {4'd7, 3'd0,2'd0,1'b0, 4'b0010,4'b1101,1'b0,1'b0}, // 21 R7
    {4'd7, 3'd0,2'd0,1'b0, 4'b0000,4'b1101,1'b1,1'b0}, // 22 R7 closes at act+TRAS
    {4'd11,3'd5,2'd0,1'b0, 4'b0000,4'b1101,1'b1,1'b1}, // 23 R11 refresh too early
    {4'd11,3'd0,2'd0,1'b0, 4'b0000,4'b1111,1'b1,1'b0}, // 24 R11
    {4'd11,3'd5,2'd0,1'b0, 4'b0000,4'b1111,1'b0,1'b0}, // 25 R11 refresh accepted
    {4'd2, 3'd1,2'd2,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 26 R2 open b2
    {4'd8, 3'd4,2'd2,1'b1, 4'b0100,4'b1011,1'b0,1'b0}, // 27 R8 write AP b2
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 28 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 29 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 30 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 31 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 32 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 33 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0000,4'b1011,1'b1,1'b0}, // 34 R8 closes at +7
    {4'd8, 3'd0,2'd0,1'b0, 4'b0000,4'b1011,1'b1,1'b0}, // 35 R8
    {4'd8, 3'd0,2'd0,1'b0, 4'b0000,4'b1111,1'b1,1'b0}, // 36 R8
    {4'd8, 3'd1,2'd2,1'b0, 4'b0100,4'b1011,1'b0,1'b0}, // 37 R8 act at +10
    {4'd2, 3'd1,2'd3,1'b0, 4'b1100,4'b0011,1'b0,1'b0}, // 38 R2 open b3
    {4'd5, 3'd0,2'd0,1'b0, 4'b1100,4'b0011,1'b0,1'b0}, // 39 R5
    {4'd5, 3'd0,2'd0,1'b0, 4'b1100,4'b0011,1'b0,1'b0}, // 40 R5
    {4'd5, 3'd0,2'd0,1'b0, 4'b1100,4'b0011,1'b0,1'b0}, // 41 R5
    {4'd5, 3'd0,2'd0,1'b0, 4'b1100,4'b0011,1'b0,1'b0}, // 42 R5
    {4'd4, 3'd2,2'd0,1'b1, 4'b1000,4'b0011,1'b1,1'b1}, // 43 R4 all: b2 closes, b3 young
    {4'd4, 3'd2,2'd0,1'b1, 4'b0000,4'b0011,1'b1,1'b0}, // 44 R4 all again
    {4'd3, 3'd1,2'd3,1'b0, 4'b0000,4'b0111,1'b1,1'b1}, // 45 R3 act inside TRP
    {4'd6, 3'd0,2'd0,1'b0, 4'b0000,4'b1111,1'b1,1'b0}, // 46 R6
    {4'd10,3'd4,2'd0,1'b0, 4'b0000,4'b1111,1'b0,1'b1}  // 47 R10 write closed bank
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] e_open,
                           input logic [3:0] e_ready, input logic e_busy,
                           input logic e_viol);
    check(req, "bank_open", 32'(bank_open), 32'(e_open));
    check(req, "act_ready", 32'(act_ready), 32'(e_ready));
    check(req, "pre_busy",  32'(pre_busy),  32'(e_busy));
    check(req, "violation", 32'(violation), 32'(e_viol));
    check("R11", "ref_ok",    32'(ref_ok),    32'(&e_ready));
    check("R12", "pd_active", 32'(pd_active), 32'(|e_open));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("R1", 4'b0000, 4'b1111, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cmd_op   = VEC[i][15:13];
      cmd_bank = VEC[i][12:11];
      cmd_flag = VEC[i][10];
      @(negedge clk);
      check_all($sformatf("R%0d", VEC[i][19:16]), VEC[i][9:6],
                VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R1 undefined opcode 7 behaves as no-op on an open bank
    cmd_op = 3'd1; cmd_bank = 2'd1; cmd_flag = 1'b0;
    @(negedge clk);
    cmd_op = 3'd7; cmd_bank = 2'd1; cmd_flag = 1'b1;
    @(negedge clk);
    check_all("R1", 4'b0010, 4'b1101, 1'b0, 1'b0);

    // R1 reset in the middle of activity returns to idle
    cmd_op = 3'd0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1", 4'b0000, 4'b1111, 1'b0, 1'b0);

    // R13 back-to-back violations, then a legal command clears the flag
    cmd_op = 3'd3; cmd_bank = 2'd2; cmd_flag = 1'b0;
    @(negedge clk);
    check("R13", "violation", 32'(violation), 32'd1);
    cmd_op = 3'd4; cmd_bank = 2'd3;
    @(negedge clk);
    check("R13", "violation", 32'(violation), 32'd1);
    cmd_op = 3'd0;
    @(negedge clk);
    check("R13", "violation", 32'(violation), 32'd0);

    finish_run();
  end
endmodule